// File: doc/BRIEF.md
# Bidirectional Doorbell Interrupt Register

The block lets a host-bus side and an embedded-processor side exchange single 32-bit words. Each side has its own register-access port. A write to a side's message register posts one word toward the other side, sets a sticky pending flag for that direction and, unless the receiver has masked it, raises an interrupt toward the receiver. The receiver reads the word, reads its status, and acknowledges by writing ones to the status bits it wants to clear. Each direction has its own data register, pending flag, overrun flag, mask and interrupt. Both sides run on one clock.

Both access ports are plain register strobes, not streams. A write or read completes in the cycle its strobe is high, and there is no back-pressure. Read data is combinational from the current register state while `*_rd` is high, and is zero otherwise. Side-port address map, identical on both sides:

- 0: message. A write posts the word outbound. A read returns the inbound word.
- 1: inbound status. Bit 0 is pending and bit 1 is overrun. Writing a 1 to a bit clears it.
- 2: inbound mask. Bit 0 set disables the inbound interrupt.
- 3: outbound status. Bit 0 shows that the word this side posted is still unacknowledged.

Top module: `doorbell_pair`

## Requirements
- R1: After reset both message registers read 0, both status registers read 0, both masks read 1, address 3 reads 0 on both sides, and both interrupt outputs are low.
- R2: A host write to address 0 stores the word for the processor side and sets that direction's pending bit. The processor then reads the word at its address 0 and sees bit 0 set at its address 1.
- R3: A processor write to address 0 stores the word for the host side in a separate register. The host reads it at its address 0, and the host-to-processor word is left unchanged.
- R4: Each interrupt output is a registered copy of (pending AND NOT mask) for its inbound direction. It changes on the clock edge after the edge that updated pending or mask, and stays low while the mask bit is 1.
- R5: Writing status (address 1) with bit 0 = 1 clears pending, and with bit 1 = 1 clears overrun. Zero bits leave their flag unchanged.
- R6: A post that arrives while pending is already set replaces the stored word, keeps pending set and sets the overrun bit (status bit 1).
- R7: When a post and a pending-clear for the same direction fall in the same cycle, pending stays set and the new word is stored.
- R8: A side reads its outbound pending flag at address 3, bit 0. The flag is 1 from its post until the receiver clears it.
- R9: The mask (address 2, bit 0) is writable and reads back. Setting it again drops an asserted interrupt on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data |
| proc_wr | input | 1 | Processor write strobe |
| proc_rd | input | 1 | Processor read strobe |
| proc_addr | input | 2 | Processor register address |
| proc_wdata | input | 32 | Processor write data |
| proc_rdata | output | 32 | Processor read data |
| host_irq | output | 1 | Interrupt toward the host (processor-to-host direction) |
| proc_irq | output | 1 | Interrupt toward the processor (host-to-processor direction) |

## Verification
A lost or stuck pending bit shows directly in the receiver's status read and in the sender's address-3 read on the cycle after the write. It shows in the interrupt one edge later. Crossed direction wiring makes a word appear on the writer's own side, or makes the wrong interrupt rise, which reads of both message registers after opposite posts expose at once. A wrong priority between post and clear, or missing overrun logic, shows up only in the collision tests, as a status value of 0 instead of 1 or 1 instead of 3 on the very next read.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] REG_MSG     = 2'd0;
  localparam logic [ADDR_W-1:0] REG_IN_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] REG_IN_MASK = 2'd2;
  localparam logic [ADDR_W-1:0] REG_OUT_ST  = 2'd3;

  localparam int unsigned STAT_PEND_BIT = 0;
  localparam int unsigned STAT_OVR_BIT  = 1;
  localparam int unsigned MASK_BIT      = 0;

  localparam int unsigned NUM_SIDES = 2;
endpackage

// File: rtl/doorbell_lane.sv
module doorbell_lane #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          post_i,
  input  logic [DW-1:0] post_data_i,
  input  logic          clr_pend_i,
  input  logic          clr_ovr_i,
  input  logic          mask_we_i,
  input  logic          mask_val_i,
  output logic [DW-1:0] data_o,
  output logic          pend_o,
  output logic          ovr_o,
  output logic          mask_o,
  output logic          irq_o
);
  logic [DW-1:0] data_q;
  logic          pend_q, ovr_q, mask_q, irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
      mask_q <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      if (post_i) data_q <= post_data_i;
      if (post_i)          pend_q <= 1'b1;
      else if (clr_pend_i) pend_q <= 1'b0;
      if (post_i && pend_q) ovr_q <= 1'b1;
      else if (clr_ovr_i)   ovr_q <= 1'b0;
      if (mask_we_i) mask_q <= mask_val_i;
      irq_q <= pend_q & ~mask_q;
    end
  end

  assign data_o = data_q;
  assign pend_o = pend_q;
  assign ovr_o  = ovr_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  AST_POST_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    post_i |=> (pend_q && data_q == $past(post_data_i))); // R2
  AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (post_i && pend_q) |=> ovr_q); // R6
  AST_CLEAR_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pend_i && !post_i) |=> !pend_q); // R5
  AST_POST_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pend_i && post_i) |=> pend_q); // R7
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |=> !irq_q); // R4
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !mask_q) |=> irq_q); // R4
endmodule

// File: rtl/doorbell_side_port.sv
module doorbell_side_port
  import doorbell_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW-1:0]     in_data_i,
  input  logic              in_pend_i,
  input  logic              in_ovr_i,
  input  logic              in_mask_i,
  input  logic              out_pend_i,
  output logic              post_o,
  output logic              clr_pend_o,
  output logic              clr_ovr_o,
  output logic              mask_we_o,
  output logic              mask_val_o,
  output logic [DW-1:0]     rdata_o
);
  always_comb begin
    post_o     = wr_i && (addr_i == REG_MSG);
    clr_pend_o = wr_i && (addr_i == REG_IN_STAT) && wdata_i[STAT_PEND_BIT];
    clr_ovr_o  = wr_i && (addr_i == REG_IN_STAT) && wdata_i[STAT_OVR_BIT];
    mask_we_o  = wr_i && (addr_i == REG_IN_MASK);
    mask_val_o = wdata_i[MASK_BIT];
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        REG_MSG:     rdata_o = in_data_i;
        REG_IN_STAT: begin
          rdata_o[STAT_PEND_BIT] = in_pend_i;
          rdata_o[STAT_OVR_BIT]  = in_ovr_i;
        end
        REG_IN_MASK: rdata_o[MASK_BIT] = in_mask_i;
        REG_OUT_ST:  rdata_o[STAT_PEND_BIT] = out_pend_i;
        default:     rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/doorbell_pair.sv
module doorbell_pair
  import doorbell_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  input  logic              proc_wr,
  input  logic              proc_rd,
  input  logic [ADDR_W-1:0] proc_addr,
  input  logic [DW-1:0]     proc_wdata,
  output logic [DW-1:0]     proc_rdata,
  output logic              host_irq,
  output logic              proc_irq
);
  // Side 0 = host, side 1 = processor. Lane s carries words posted by side s.
  logic              wr_a     [NUM_SIDES];
  logic              rd_a     [NUM_SIDES];
  logic [ADDR_W-1:0] addr_a   [NUM_SIDES];
  logic [DW-1:0]     wdata_a  [NUM_SIDES];
  logic [DW-1:0]     rdata_a  [NUM_SIDES];
  logic              post_a   [NUM_SIDES];
  logic              clrp_a   [NUM_SIDES];
  logic              clro_a   [NUM_SIDES];
  logic              mwe_a    [NUM_SIDES];
  logic              mval_a   [NUM_SIDES];
  logic [DW-1:0]     ldata_a  [NUM_SIDES];
  logic              lpend_a  [NUM_SIDES];
  logic              lovr_a   [NUM_SIDES];
  logic              lmask_a  [NUM_SIDES];
  logic              lirq_a   [NUM_SIDES];

  assign wr_a[0]    = host_wr;
  assign rd_a[0]    = host_rd;
  assign addr_a[0]  = host_addr;
  assign wdata_a[0] = host_wdata;
  assign wr_a[1]    = proc_wr;
  assign rd_a[1]    = proc_rd;
  assign addr_a[1]  = proc_addr;
  assign wdata_a[1] = proc_wdata;

  assign host_rdata = rdata_a[0];
  assign proc_rdata = rdata_a[1];
  assign proc_irq   = lirq_a[0];
  assign host_irq   = lirq_a[1];

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    localparam int unsigned PEER = NUM_SIDES - 1 - s;

    doorbell_side_port #(.DW(DW)) port_i (
      .wr_i       (wr_a[s]),
      .rd_i       (rd_a[s]),
      .addr_i     (addr_a[s]),
      .wdata_i    (wdata_a[s]),
      .in_data_i  (ldata_a[PEER]),
      .in_pend_i  (lpend_a[PEER]),
      .in_ovr_i   (lovr_a[PEER]),
      .in_mask_i  (lmask_a[PEER]),
      .out_pend_i (lpend_a[s]),
      .post_o     (post_a[s]),
      .clr_pend_o (clrp_a[s]),
      .clr_ovr_o  (clro_a[s]),
      .mask_we_o  (mwe_a[s]),
      .mask_val_o (mval_a[s]),
      .rdata_o    (rdata_a[s])
    );

    doorbell_lane #(.DW(DW)) lane_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .post_i      (post_a[s]),
      .post_data_i (wdata_a[s]),
      .clr_pend_i  (clrp_a[PEER]),
      .clr_ovr_i   (clro_a[PEER]),
      .mask_we_i   (mwe_a[PEER]),
      .mask_val_i  (mval_a[PEER]),
      .data_o      (ldata_a[s]),
      .pend_o      (lpend_a[s]),
      .ovr_o       (lovr_a[s]),
      .mask_o      (lmask_a[s]),
      .irq_o       (lirq_a[s])
    );
  end

  AST_RESET_IRQ_LOW: assert property (@(posedge clk)
    !rst_n |=> (!host_irq && !proc_irq)); // R1
  AST_HOST_POST_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == REG_MSG) |=> lpend_a[0]); // R2
  AST_PROC_POST_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_wr && proc_addr == REG_MSG) |=> lpend_a[1]); // R3
endmodule

// File: tb/doorbell_pair_tb_top.sv
`timescale 1ns/1ps
module doorbell_pair_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 0, host_rd = 0, proc_wr = 0, proc_rd = 0;
  logic [1:0]  host_addr = 0, proc_addr = 0;
  logic [31:0] host_wdata = 0, proc_wdata = 0;
  logic [31:0] host_rdata, proc_rdata;
  logic        host_irq, proc_irq;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit          side;
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  doorbell_pair dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .proc_wr(proc_wr), .proc_rd(proc_rd), .proc_addr(proc_addr),
    .proc_wdata(proc_wdata), .proc_rdata(proc_rdata),
    .host_irq(host_irq), .proc_irq(proc_irq)
  );

  // Monitor: pops the scoreboard on each read strobe, away from the edge.
  always @(negedge clk) begin
    if (host_rd || proc_rd) begin
      exp_t e;
      logic [31:0] act;
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard empty on read: actual %h expected an entry", host_rd ? host_rdata : proc_rdata);
      end else begin
        e = sb.pop_front();
        act = e.side ? proc_rdata : host_rdata;
        checks++;
        if (act !== e.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", e.tag, act, e.exp);
        end
      end
    end
  end

  task automatic wr(input bit side, input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    if (side) begin proc_wr = 1; proc_addr = a; proc_wdata = d; end
    else      begin host_wr = 1; host_addr = a; host_wdata = d; end
    @(posedge clk); #1;
    host_wr = 0; proc_wr = 0;
  endtask

  task automatic wr_both(input logic [1:0] ha, input logic [31:0] hd,
                         input logic [1:0] pa, input logic [31:0] pd);
    @(posedge clk); #1;
    host_wr = 1; host_addr = ha; host_wdata = hd;
    proc_wr = 1; proc_addr = pa; proc_wdata = pd;
    @(posedge clk); #1;
    host_wr = 0; proc_wr = 0;
  endtask

  // Driver: pushes the expected value, then raises the read strobe.
  task automatic rd(input bit side, input logic [1:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    it.side = side; it.exp = e; it.tag = tag;
    @(posedge clk); #1;
    sb.push_back(it);
    if (side) begin proc_rd = 1; proc_addr = a; end
    else      begin host_rd = 1; host_addr = a; end
    @(posedge clk); #1;
    host_rd = 0; proc_rd = 0;
  endtask

  task automatic chk_irq(input logic eh, input logic ep, input string tag);
    @(posedge clk); @(negedge clk);
    checks++;
    if (host_irq !== eh || proc_irq !== ep) begin
      errors++;
      $display("FAIL %s: actual host_irq=%b proc_irq=%b expected %b %b", tag, host_irq, proc_irq, eh, ep);
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(0, 2'd0, 32'h0, "R1 host msg");
    rd(1, 2'd0, 32'h0, "R1 proc msg");
    rd(0, 2'd1, 32'h0, "R1 host status");
    rd(1, 2'd2, 32'h1, "R1 proc mask");
    rd(0, 2'd2, 32'h1, "R1 host mask");
    rd(1, 2'd3, 32'h0, "R1 proc outbound");
    chk_irq(0, 0, "R1 irqs low");

    // R2 host posts, masked so no irq (R4)
    wr(0, 2'd0, 32'hA5A5_0001);
    chk_irq(0, 0, "R4 masked stays low");
    rd(1, 2'd1, 32'h1, "R2 proc pending");
    rd(1, 2'd0, 32'hA5A5_0001, "R2 proc reads word");
    rd(0, 2'd3, 32'h1, "R8 host outbound pending");

    // R9 / R4 unmask
    wr(1, 2'd2, 32'h0);
    chk_irq(0, 1, "R4 unmask raises proc irq");
    rd(1, 2'd2, 32'h0, "R9 mask readback");

    // R6 overrun
    wr(0, 2'd0, 32'hB00B_0002);
    rd(1, 2'd1, 32'h3, "R6 overrun status");
    rd(1, 2'd0, 32'hB00B_0002, "R6 word replaced");

    // R3 opposite direction independent
    wr(1, 2'd0, 32'hC0DE_0003);
    rd(0, 2'd0, 32'hC0DE_0003, "R3 host reads word");
    rd(1, 2'd0, 32'hB00B_0002, "R3 other direction untouched");
    rd(0, 2'd1, 32'h1, "R3 host pending");
    chk_irq(0, 1, "R4 host irq masked");

    // R5 clear pending only, then overrun
    wr(1, 2'd1, 32'h1);
    rd(1, 2'd1, 32'h2, "R5 pending cleared overrun kept");
    chk_irq(0, 0, "R4 proc irq drops");
    rd(0, 2'd3, 32'h0, "R8 host outbound cleared");
    wr(1, 2'd1, 32'h2);
    rd(1, 2'd1, 32'h0, "R5 overrun cleared");

    // R7 post and clear in the same cycle
    wr_both(2'd0, 32'hD00D_0004, 2'd1, 32'h1);
    rd(1, 2'd1, 32'h1, "R7 pending kept");
    rd(1, 2'd0, 32'hD00D_0004, "R7 new word stored");

    // R4 host side unmask and ack
    wr(0, 2'd2, 32'h0);
    chk_irq(1, 1, "R4 host irq rises");
    wr(0, 2'd1, 32'h1);
    chk_irq(0, 1, "R4 host irq drops on ack");
    rd(1, 2'd3, 32'h0, "R8 proc outbound cleared");

    // R9 remask drops asserted irq
    wr(1, 2'd2, 32'h1);
    chk_irq(0, 0, "R9 remask drops proc irq");

    repeat (2) @(posedge clk);
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard leftover: actual %0d expected 0", sb.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule